// File: doc/BRIEF.md
# Prioritized Register Transfer Controller

This block owns two counters, X and Y, and three request-driven processes that act on them. The increment process adds one to X. The transfer process moves one unit out of X and into Y. The drain process takes one from Y. Each process has its own request input. A fixed priority, chosen at elaboration time, decides which requests are granted in a cycle. Processes that touch different counters are granted together.

The transfer is indivisible. Either both counters change together or neither changes. The fire vector is combinational from the requests. It shows in the current cycle which processes are granted, and the counters take the granted updates on the next rising edge.

A single parameter selects one of the six priority orderings. The grant logic is built from that parameter and from a table that records which counters each process touches. The counters wrap modulo two to the counter width.

Top module: `prio_xfer_ctrl`

## Requirements
- R1: While reset is held and at the first edge after reset is released, both counter outputs read zero.
- R2: A process's fire bit is never high unless its own request bit is high. Process k uses bit k of both `req_i` and `fire_o`.
- R3: When the increment process (bit 0) fires, X is one higher after the next rising edge.
- R4: When the transfer process (bit 1) fires, X is one lower and Y is one higher after the same rising edge. One counter never changes without the other.
- R5: When the drain process (bit 2) fires, Y is one lower after the next rising edge.
- R6: In any cycle, no counter is written by two processes. Bits 0 and 1 never fire together, and bits 1 and 2 never fire together.
- R7: With the default ordering (PRIO_SEL=0: drain over transfer over increment), the transfer fires only when it is requested and the drain is not requested. The increment fires when it is requested and either the transfer is not requested or the drain is requested.
- R8: Whenever the transfer is not firing, requested increment and drain processes both fire in the same cycle.
- R9: PRIO_SEL selects the ordering, listed highest to lowest: 0 = 2,1,0; 1 = 2,0,1; 2 = 1,2,0; 3 = 1,0,2; 4 = 0,2,1; 5 = 0,1,2. A process fires if and only if it is requested and no higher-ranked process that shares a counter with it fires. The highest-ranked process therefore fires whenever it is requested.
- R10: In a cycle where no process fires, both counters hold their values.
- R11: The counters wrap. Draining Y at zero gives all ones, and incrementing at all ones gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_i | input | 3 | Request per process: bit 0 increment, bit 1 transfer, bit 2 drain |
| x_o | output | CNT_W | Current value of counter X |
| y_o | output | CNT_W | Current value of counter Y |
| fire_o | output | 3 | Grant per process in the current cycle, same bit order as req_i |

## Verification
The fire vector is due in the same cycle as the requests. The bench drives requests just after a falling edge and compares `fire_o` one time unit later, before any rising edge. The counter effects are due one rising edge later, so X and Y are compared at the following falling edge against a behavioural model that has applied that cycle's grants. Two instances run the same stimulus, one with the default ordering and one with PRIO_SEL=2, so that every conflict pattern is checked under both orderings.

// File: rtl/prio_xfer_pkg.sv
package prio_xfer_pkg;

   localparam int unsigned N_PROC   = 3;
   localparam int unsigned N_REG    = 2;
   localparam int unsigned N_ORDERS = 6;

   typedef logic [N_PROC-1:0] proc_vec_t;
   typedef logic [N_REG-1:0]  reg_vec_t;

   // Which counters each process writes: bit 0 = X, bit 1 = Y.
   function automatic reg_vec_t touches(input int unsigned p);
      case (p)
         0:       return 2'b01;
         1:       return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

   // Processes that share at least one counter with process p.
   function automatic proc_vec_t conflict_mask(input int unsigned p);
      proc_vec_t m = '0;
      for (int unsigned q = 0; q < N_PROC; q++) begin
         if (q != p && (touches(p) & touches(q)) != '0) m[q] = 1'b1;
      end
      return m;
   endfunction

   // Process that sits at rank pos (0 = highest) under ordering sel.
   function automatic int unsigned prio_at(input int unsigned sel, input int unsigned pos);
      int unsigned lead;
      int unsigned a;
      int unsigned b;
      lead = 2 - (sel / 2);
      a    = (lead == 0) ? 1 : 0;
      b    = (lead == 2) ? 1 : 2;
      if (sel % 2 == 0) begin
         // remaining two in descending index order
         if (pos == 0) return lead;
         if (pos == 1) return b;
         return a;
      end
      if (pos == 0) return lead;
      if (pos == 1) return a;
      return b;
   endfunction

endpackage

// File: rtl/prio_xfer_grant.sv
module prio_xfer_grant
   import prio_xfer_pkg::*;
#(
   parameter int unsigned PRIO_SEL = 0
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  proc_vec_t req_i,
   output proc_vec_t fire_o
);

   localparam int unsigned TOP = prio_at(PRIO_SEL, 0);

   proc_vec_t granted [N_PROC+1];

   assign granted[0] = '0;

   for (genvar pos = 0; pos < N_PROC; pos++) begin : g_rank
      localparam int unsigned P         = prio_at(PRIO_SEL, pos);
      localparam proc_vec_t   SELF_BIT  = proc_vec_t'(1) << P;
      localparam proc_vec_t   BLOCKERS  = conflict_mask(P);
      logic free;
      assign free = (granted[pos] & BLOCKERS) == '0;
      assign granted[pos+1] = (req_i[P] && free) ? (granted[pos] | SELF_BIT) : granted[pos];
   end

   assign fire_o = granted[N_PROC];

   AST_FIRE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o & ~req_i) == '0); // R2

   AST_NO_SHARED_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(fire_o[0] && fire_o[1]) && !(fire_o[1] && fire_o[2])); // R6

   AST_TOP_RANK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[TOP] |-> fire_o[TOP]); // R9

   AST_OUTER_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[0] && req_i[2] && !fire_o[1]) |-> (fire_o[0] && fire_o[2])); // R8

endmodule

// File: rtl/prio_xfer_cnt.sv
module prio_xfer_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   input  logic         dec_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] q_r;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      q_r <= '0;
      else if (inc_i)   q_r <= q_r + 1'b1;
      else if (dec_i)   q_r <= q_r - 1'b1;
   end

   assign q_o = q_r;

   AST_CNT_ONE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(inc_i && dec_i)); // R6

endmodule

// File: rtl/prio_xfer_ctrl.sv
module prio_xfer_ctrl
   import prio_xfer_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned PRIO_SEL = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [2:0]       req_i,
   output logic [CNT_W-1:0] x_o,
   output logic [CNT_W-1:0] y_o,
   output logic [2:0]       fire_o
);

   if (PRIO_SEL >= N_ORDERS) begin : g_bad_sel
      $error("PRIO_SEL must be below %0d", N_ORDERS);
   end
   if (CNT_W < 1) begin : g_bad_width
      $error("CNT_W must be at least 1");
   end

   proc_vec_t        fire;
   reg_vec_t         inc_c;
   reg_vec_t         dec_c;
   logic [CNT_W-1:0] cnt_q [N_REG];

   prio_xfer_grant #(.PRIO_SEL(PRIO_SEL)) u_grant (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req_i),
      .fire_o (fire)
   );

   // X: raised by process 0, lowered by process 1. Y: raised by 1, lowered by 2.
   assign inc_c = {fire[1], fire[0]};
   assign dec_c = {fire[2], fire[1]};

   for (genvar r = 0; r < N_REG; r++) begin : g_cnt
      prio_xfer_cnt #(.W(CNT_W)) u_cnt (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .inc_i  (inc_c[r]),
         .dec_i  (dec_c[r]),
         .q_o    (cnt_q[r])
      );
   end

   assign x_o    = cnt_q[0];
   assign y_o    = cnt_q[1];
   assign fire_o = fire;

   AST_XFER_ATOMIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o[1] |=> (x_o == $past(x_o) - 1'b1) && (y_o == $past(y_o) + 1'b1)); // R4

   AST_INC_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o[0] |=> x_o == $past(x_o) + 1'b1); // R3

   AST_DEC_Y: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o[2] |=> y_o == $past(y_o) - 1'b1); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o == 3'b000 |=> $stable(x_o) && $stable(y_o)); // R10

endmodule

// File: tb/prio_xfer_ctrl_tb_top.sv
module prio_xfer_ctrl_tb_top;

   logic       clk;
   logic       rst_n;
   logic [2:0] req;
   logic [7:0] x_d, y_d, x_a, y_a;
   logic [2:0] f_d, f_a;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   // reference state: default order 2,1,0 and alternative order 1,2,0
   logic [7:0] mx_d = 0, my_d = 0, mx_a = 0, my_a = 0;
   int ord_d[3] = '{2, 1, 0};
   int ord_a[3] = '{1, 2, 0};

   prio_xfer_ctrl #(.CNT_W(8), .PRIO_SEL(0)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .x_o(x_d), .y_o(y_d), .fire_o(f_d));

   prio_xfer_ctrl #(.CNT_W(8), .PRIO_SEL(2)) dut_alt_i (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .x_o(x_a), .y_o(y_a), .fire_o(f_a));

   initial clk = 0;
   always #4 clk = ~clk;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // grant model: each process claims the counters it uses, in rank order
   function automatic logic [2:0] model_fire(input logic [2:0] r, input int ord[3]);
      bit used_x = 0, used_y = 0;
      logic [2:0] f = 0;
      foreach (ord[i]) begin
         int p = ord[i];
         bit nx = (p == 0 || p == 1);
         bit ny = (p == 1 || p == 2);
         if (r[p] && !(nx && used_x) && !(ny && used_y)) begin
            f[p] = 1;
            if (nx) used_x = 1;
            if (ny) used_y = 1;
         end
      end
      return f;
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // Called just after a falling edge.
   task automatic do_cycle(input logic [2:0] r, input string tag);
      logic [2:0] ef_d, ef_a;
      req = r;
      #1;
      ef_d = model_fire(r, ord_d);
      ef_a = model_fire(r, ord_a);
      chk(tag,  "fire default", int'(f_d), int'(ef_d));
      chk("R9", "fire alt",     int'(f_a), int'(ef_a));
      @(posedge clk);
      if (ef_d[0]) mx_d = mx_d + 1;
      if (ef_d[1]) begin mx_d = mx_d - 1; my_d = my_d + 1; end
      if (ef_d[2]) my_d = my_d - 1;
      if (ef_a[0]) mx_a = mx_a + 1;
      if (ef_a[1]) begin mx_a = mx_a - 1; my_a = my_a + 1; end
      if (ef_a[2]) my_a = my_a - 1;
      @(negedge clk);
      chk(tag,  "x default", int'(x_d), int'(mx_d));
      chk(tag,  "y default", int'(y_d), int'(my_d));
      chk("R9", "x alt",     int'(x_a), int'(mx_a));
      chk("R9", "y alt",     int'(y_a), int'(my_a));
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      rst_n = 0;
      req   = 3'b000;
      repeat (3) @(negedge clk);
      chk("R1", "x in reset", int'(x_d), 0);
      chk("R1", "y in reset", int'(y_d), 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "x after reset", int'(x_d), 0);
      chk("R1", "y after reset", int'(y_a), 0);

      repeat (4) do_cycle(3'b001, "R3");
      repeat (2) do_cycle(3'b010, "R4");
      do_cycle(3'b100, "R5");
      do_cycle(3'b101, "R8");
      repeat (2) do_cycle(3'b000, "R10");
      do_cycle(3'b011, "R7");
      do_cycle(3'b110, "R7");
      do_cycle(3'b111, "R6");
      do_cycle(3'b111, "R7");

      for (int k = 0; k < 300 && my_d != 0; k++) do_cycle(3'b100, "R5");
      do_cycle(3'b100, "R11");
      chk("R11", "y wrapped", int'(y_d), 255);

      for (int p = 0; p < 8; p++) do_cycle(3'(p), "R2");
      for (int k = 0; k < 400; k++) do_cycle(3'($urandom_range(0, 7)), "R6");

      finish_run();
   end

endmodule